// File: doc/BRIEF.md
# Two-Channel Serial Interrupt Vector Generator

This block gathers interrupt requests from two serial channels and presents them to an 8-bit CPU that uses vectored interrupts. Channel A and channel B each have four causes: transmit buffer empty, status change, receive data available and external/status event. A one-cycle request pulse from a peripheral marks its cause pending. While any enabled cause is pending, the active-low interrupt line is held low.

When the CPU runs its interrupt-acknowledge cycle, the block places an even vector on the data input. The vector indexes a table of two-byte handler addresses based at 0x40. The vector is chosen by a fixed priority and captured when the acknowledge starts. A pending cause is removed only when the serviced peripheral pulses that cause's own clear input. A mask register lets software take any cause out of both the interrupt line and the arbitration.

Top module: `irq_vec_ctrl`

## Requirements
- R1: After reset, no cause is pending, all eight causes are enabled in the mask, `int_n` is 1, `vec_oe` is 0 and `vec_out` is 0.
- R2: A 1 on `src_req[i]` at a clock edge makes cause i pending from that edge onward. If cause i is enabled, `int_n` reads 0 from that edge.
- R3: Source index i equals channel*4 + cause, where channel B=0 and A=1, and cause is transmit-empty=0, status=1, receive=2, external=3. The vector driven for source i is 0x40 + 2*i, which gives B: 0x40/0x42/0x44/0x46 and A: 0x48/0x4A/0x4C/0x4E.
- R4: Among the enabled pending causes, channel A beats channel B. Within a channel the order is receive, then transmit-empty, then external, then status.
- R5: An acknowledge is `iorq_n`=0, `m1_n`=0 and `mreq_n`=1 together. `vec_oe` can be 1 only during an acknowledge. When `vec_oe` is 0, `vec_out` is 0.
- R6: The vector is chosen in the first cycle of an acknowledge and held unchanged until the acknowledge ends, even if a higher-priority cause becomes pending meanwhile.
- R7: A 1 on `src_clr[i]` at a clock edge clears cause i. If `src_req[i]` is also 1 at that edge, the request wins and the cause stays pending.
- R8: An acknowledge by itself clears nothing. The same cause wins again on the next acknowledge.
- R9: When `mask_we` is 1 at an edge, `mask_wdata` is loaded into the mask, where bit i = 1 enables cause i. A masked pending cause does not pull `int_n` low and does not win arbitration, but it stays recorded. Unmasking it pulls `int_n` low.
- R10: If no enabled cause is pending when an acknowledge starts, `vec_oe` stays 0 for the whole acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_req | input | 8 | One-cycle request pulses, indexed as in R3 |
| src_clr | input | 8 | One-cycle clear pulses, indexed as in R3 |
| mask_we | input | 1 | Loads the enable mask |
| mask_wdata | input | 8 | New enable mask, 1 = enabled |
| iorq_n | input | 1 | CPU I/O request, active low |
| m1_n | input | 1 | CPU opcode-fetch/acknowledge marker, active low |
| mreq_n | input | 1 | CPU memory request, active low |
| int_n | output | 1 | Interrupt request to the CPU, active low |
| vec_oe | output | 1 | Vector is valid for the CPU data input |
| vec_out | output | 8 | Interrupt vector, 0 when not driven |

## Verification
The first pattern raises each of the eight causes alone and acknowledges it. This pins down the index-to-vector mapping with no arbitration involved. The second raises all eight causes together and services them one at a time, so the sequence of vectors shows the whole priority order. Further patterns start an acknowledge and then raise a higher cause partway through, which separates a held vector from a live one. Repeated acknowledges without a clear show that acknowledge is not a clear. A masked cause and an acknowledge with nothing pending tell masking and spurious-acknowledge handling apart from normal arbitration. Bus states that resemble an acknowledge (memory cycle active, or M1 high) confirm that the vector is driven only in a true acknowledge.

// File: rtl/irqv_pkg.sv
package irqv_pkg;
  localparam int CAUSES = 4;

  typedef enum logic [1:0] {
    C_TXE  = 2'd0,
    C_STAT = 2'd1,
    C_RXA  = 2'd2,
    C_EXT  = 2'd3
  } cause_e;

  function automatic int src_index(input int ch, input cause_e c);
    return ch * CAUSES + int'(c);
  endfunction

  // rank 0 is the highest priority; higher channel numbers win first
  function automatic int rank_to_src(input int rank, input int nch);
    cause_e c;
    int ch;
    ch = nch - 1 - rank / CAUSES;
    case (rank % CAUSES)
      0:       c = C_RXA;
      1:       c = C_TXE;
      2:       c = C_EXT;
      default: c = C_STAT;
    endcase
    return src_index(ch, c);
  endfunction

  function automatic logic [7:0] vec_of(input logic [7:0] base, input int stride, input int idx);
    return base + 8'(stride * idx);
  endfunction
endpackage

// File: rtl/irqv_pending.sv
module irqv_pending #(
  parameter int NSRC = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_req,
  input  logic [NSRC-1:0] src_clr,
  input  logic            mask_we,
  input  logic [NSRC-1:0] mask_wdata,
  output logic [NSRC-1:0] pend_q,
  output logic [NSRC-1:0] mask_q,
  output logic [NSRC-1:0] cand
);
  for (genvar i = 0; i < NSRC; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          pend_q[i] <= 1'b0;
      else if (src_req[i]) pend_q[i] <= 1'b1;
      else if (src_clr[i]) pend_q[i] <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '1;
    else if (mask_we) mask_q <= mask_wdata;
  end

  assign cand = pend_q & mask_q;
endmodule

// File: rtl/irqv_arbiter.sv
module irqv_arbiter
  import irqv_pkg::*;
#(
  parameter int NCH  = 2,
  parameter int NSRC = NCH * CAUSES,
  parameter int IW   = $clog2(NSRC)
) (
  input  logic [NSRC-1:0] cand,
  output logic            win_valid,
  output logic [IW-1:0]   win_idx,
  output logic [NSRC-1:0] win_oh
);
  always_comb begin
    win_valid = 1'b0;
    win_idx   = '0;
    for (int r = NSRC - 1; r >= 0; r--) begin
      if (cand[rank_to_src(r, NCH)]) begin
        win_valid = 1'b1;
        win_idx   = IW'(rank_to_src(r, NCH));
      end
    end
    win_oh = '0;
    if (win_valid) win_oh[win_idx] = 1'b1;
  end
endmodule

// File: rtl/irqv_ack.sv
module irqv_ack (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       iorq_n,
  input  logic       m1_n,
  input  logic       mreq_n,
  input  logic       win_valid,
  input  logic [7:0] win_vec,
  output logic       ack,
  output logic       ack_first,
  output logic       vec_oe,
  output logic [7:0] vec_out
);
  logic       ack_q;
  logic       held_valid;
  logic [7:0] held_vec;

  assign ack       = !iorq_n && !m1_n && mreq_n;
  assign ack_first = ack && !ack_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_q      <= 1'b0;
      held_valid <= 1'b0;
      held_vec   <= '0;
    end else begin
      ack_q <= ack;
      if (ack_first) begin
        held_valid <= win_valid;
        held_vec   <= win_vec;
      end
    end
  end

  assign vec_oe  = ack && (ack_q ? held_valid : win_valid);
  assign vec_out = !vec_oe ? 8'h00 : (ack_q ? held_vec : win_vec);
endmodule

// File: rtl/irq_vec_ctrl.sv
module irq_vec_ctrl
  import irqv_pkg::*;
#(
  parameter int         NCH    = 2,
  parameter logic [7:0] BASE   = 8'h40,
  parameter int         STRIDE = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NCH*CAUSES-1:0] src_req,
  input  logic [NCH*CAUSES-1:0] src_clr,
  input  logic                  mask_we,
  input  logic [NCH*CAUSES-1:0] mask_wdata,
  input  logic                  iorq_n,
  input  logic                  m1_n,
  input  logic                  mreq_n,
  output logic                  int_n,
  output logic                  vec_oe,
  output logic [7:0]            vec_out
);
  localparam int NSRC = NCH * CAUSES;
  localparam int IW   = $clog2(NSRC);

  logic [NSRC-1:0] pend_q, mask_q, cand, win_oh;
  logic            win_valid, ack, ack_first;
  logic [IW-1:0]   win_idx;
  logic [7:0]      win_vec;

  irqv_pending #(.NSRC(NSRC)) u_pend (
    .clk(clk), .rst_n(rst_n), .src_req(src_req), .src_clr(src_clr),
    .mask_we(mask_we), .mask_wdata(mask_wdata),
    .pend_q(pend_q), .mask_q(mask_q), .cand(cand)
  );

  irqv_arbiter #(.NCH(NCH), .NSRC(NSRC), .IW(IW)) u_arb (
    .cand(cand), .win_valid(win_valid), .win_idx(win_idx), .win_oh(win_oh)
  );

  assign win_vec = vec_of(BASE, STRIDE, int'(win_idx));

  irqv_ack u_ack (
    .clk(clk), .rst_n(rst_n), .iorq_n(iorq_n), .m1_n(m1_n), .mreq_n(mreq_n),
    .win_valid(win_valid), .win_vec(win_vec),
    .ack(ack), .ack_first(ack_first), .vec_oe(vec_oe), .vec_out(vec_out)
  );

  assign int_n = ~|cand;
endmodule

// File: rtl/irqv_checker.sv
module irqv_checker #(
  parameter int         NSRC   = 8,
  parameter logic [7:0] BASE   = 8'h40,
  parameter int         STRIDE = 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NSRC-1:0] src_req,
  input logic [NSRC-1:0] src_clr,
  input logic            mask_we,
  input logic            iorq_n,
  input logic            m1_n,
  input logic            mreq_n,
  input logic            int_n,
  input logic            vec_oe,
  input logic [7:0]      vec_out,
  input logic [NSRC-1:0] pend_q,
  input logic [NSRC-1:0] mask_q,
  input logic [NSRC-1:0] cand,
  input logic            ack,
  input logic            ack_first,
  input logic [NSRC-1:0] win_oh
);
  a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (int_n && !vec_oe));

  a_r2_req_raises_int: assert property (@(posedge clk) disable iff (!rst_n)
    (((src_req & mask_q) != '0) && !mask_we) |=> !int_n);

  a_r2_req_sets: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend_q & $past(src_req)) == $past(src_req)));

  a_r3_vec_in_table: assert property (@(posedge clk) disable iff (!rst_n)
    vec_oe |-> (int'(vec_out) >= int'(BASE) &&
                int'(vec_out) <= int'(BASE) + STRIDE * (NSRC - 1) &&
                ((int'(vec_out) - int'(BASE)) % STRIDE) == 0));

  a_r4_single_winner: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(win_oh));

  a_r5_only_in_ack: assert property (@(posedge clk) disable iff (!rst_n)
    !(!iorq_n && !m1_n && mreq_n) |-> (!vec_oe && vec_out == 8'h00));

  a_r6_vec_held: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !ack_first) |-> $stable(vec_out));

  a_r7_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend_q & $past(src_clr & ~src_req)) == '0));

  a_r8_pend_kept: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend_q & $past(pend_q & ~src_clr)) == $past(pend_q & ~src_clr)));

  a_r9_masked_never_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (win_oh & ~mask_q) == '0);

  a_r10_spurious_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_first && cand == '0) |-> !vec_oe);
endmodule

bind irq_vec_ctrl irqv_checker #(.NSRC(NSRC), .BASE(BASE), .STRIDE(STRIDE)) u_chk (
  .clk(clk), .rst_n(rst_n), .src_req(src_req), .src_clr(src_clr), .mask_we(mask_we),
  .iorq_n(iorq_n), .m1_n(m1_n), .mreq_n(mreq_n), .int_n(int_n), .vec_oe(vec_oe),
  .vec_out(vec_out), .pend_q(pend_q), .mask_q(mask_q), .cand(cand), .ack(ack),
  .ack_first(ack_first), .win_oh(win_oh)
);

// File: tb/test_irq_vec_ctrl.sv
module test_irq_vec_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] src_req = '0, src_clr = '0, mask_wdata = '0;
  logic       mask_we = 1'b0;
  logic       iorq_n = 1'b1, m1_n = 1'b1, mreq_n = 1'b1;
  logic       int_n, vec_oe;
  logic [7:0] vec_out;

  int n_checks = 0, n_fail = 0;
  logic [7:0] exp_q[$];
  bit         mon_busy = 0;
  logic [7:0] mon_first;

  always #5 clk = ~clk;

  irq_vec_ctrl i_irq_vec_ctrl (
    .clk(clk), .rst_n(rst_n), .src_req(src_req), .src_clr(src_clr),
    .mask_we(mask_we), .mask_wdata(mask_wdata), .iorq_n(iorq_n), .m1_n(m1_n),
    .mreq_n(mreq_n), .int_n(int_n), .vec_oe(vec_oe), .vec_out(vec_out)
  );

  // Independent vector model: B=0, A=1; tx=0, status=1, rx=2, ext=3
  function automatic logic [7:0] model_vec(input int ch, input int cause);
    return 8'h40 | 8'(ch << 3) | 8'(cause << 1);
  endfunction

  task automatic check(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic raise(input int i);
    src_req[i] = 1'b1; step(); src_req = '0;
  endtask

  task automatic clear(input int i);
    src_clr[i] = 1'b1; step(); src_clr = '0;
  endtask

  // Acknowledge lasting three cycles; optional late request in the middle
  task automatic do_ack(input bit has, input logic [7:0] exp, input int late);
    if (has) exp_q.push_back(exp);
    iorq_n = 1'b0; m1_n = 1'b0; #1;
    check(vec_oe == has, "R5/R10 vec_oe at acknowledge", 8'(vec_oe), 8'(has));
    step();
    if (late >= 0) src_req[late] = 1'b1;
    step();
    src_req = '0;
    step();
    check(vec_oe == has, "R6/R10 vec_oe late in acknowledge", 8'(vec_oe), 8'(has));
    iorq_n = 1'b1; m1_n = 1'b1;
    step();
  endtask

  // Scoreboard monitor: pops one expected vector per acknowledge
  always @(negedge clk) begin
    if (vec_oe) begin
      if (!mon_busy) begin
        mon_busy  = 1;
        mon_first = vec_out;
        if (exp_q.size() == 0)
          check(0, "R10 unexpected vector", vec_out, 8'h00);
        else begin
          logic [7:0] e;
          e = exp_q.pop_front();
          check(vec_out == e, "R3/R4 acknowledge vector", vec_out, e);
        end
      end else if (vec_out != mon_first) begin
        check(0, "R6 vector changed in acknowledge", vec_out, mon_first);
      end
    end else mon_busy = 0;
  end

  initial begin
    #100000;
    check(0, "watchdog", 8'h00, 8'h01);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    int order [8];
    order = '{6, 4, 7, 5, 2, 0, 3, 1};
    #12 rst_n = 1'b1;
    step();
    // R1
    check(int_n == 1'b1, "R1 int_n after reset", 8'(int_n), 8'h01);
    check(vec_oe == 1'b0 && vec_out == 8'h00, "R1 vector idle", vec_out, 8'h00);

    // R2, R3, R7: each source on its own
    for (int i = 0; i < 8; i++) begin
      raise(i);
      check(int_n == 1'b0, "R2 int_n low after request", 8'(int_n), 8'h00);
      do_ack(1, model_vec(i / 4, i % 4), -1);
      clear(i);
      check(int_n == 1'b1, "R7 int_n high after clear", 8'(int_n), 8'h01);
    end

    // R4: all eight pending, serviced in priority order
    src_req = 8'hFF; step(); src_req = '0;
    for (int k = 0; k < 8; k++) begin
      do_ack(1, model_vec(order[k] / 4, order[k] % 4), -1);
      clear(order[k]);
    end
    check(int_n == 1'b1, "R4 all serviced", 8'(int_n), 8'h01);

    // R6: higher cause arrives during acknowledge of B transmit-empty
    raise(0);
    do_ack(1, model_vec(0, 0), 6);
    clear(0);
    do_ack(1, model_vec(1, 2), -1);
    clear(6);

    // R8: acknowledge alone does not clear
    raise(2);
    do_ack(1, model_vec(0, 2), -1);
    check(int_n == 1'b0, "R8 still pending after acknowledge", 8'(int_n), 8'h00);
    do_ack(1, model_vec(0, 2), -1);
    clear(2);

    // R9 / R10: mask A receive (bit 6)
    mask_wdata = 8'hBF; mask_we = 1'b1; step(); mask_we = 1'b0;
    raise(6);
    check(int_n == 1'b1, "R9 masked cause keeps int_n high", 8'(int_n), 8'h01);
    do_ack(0, 8'h00, -1);
    raise(1);
    do_ack(1, model_vec(0, 1), -1);
    clear(1);
    check(int_n == 1'b1, "R9 only masked cause left", 8'(int_n), 8'h01);
    mask_wdata = 8'hFF; mask_we = 1'b1; step(); mask_we = 1'b0;
    check(int_n == 1'b0, "R9 unmask exposes recorded cause", 8'(int_n), 8'h00);
    do_ack(1, model_vec(1, 2), -1);
    clear(6);

    // R7: request and clear in the same cycle, request wins
    src_req[0] = 1'b1; src_clr[0] = 1'b1; step(); src_req = '0; src_clr = '0;
    check(int_n == 1'b0, "R7 request beats clear", 8'(int_n), 8'h00);

    // R5: look-alike bus states must not drive the vector
    iorq_n = 1'b0; m1_n = 1'b0; mreq_n = 1'b0; #1;
    check(vec_oe == 1'b0 && vec_out == 8'h00, "R5 memory cycle active", vec_out, 8'h00);
    mreq_n = 1'b1; m1_n = 1'b1; #1;
    check(vec_oe == 1'b0 && vec_out == 8'h00, "R5 plain I/O cycle", vec_out, 8'h00);
    iorq_n = 1'b1;
    step();
    clear(0);
    check(int_n == 1'b1, "R7 cleared at end", 8'(int_n), 8'h01);

    step();
    check(exp_q.size() == 0, "R3 every expected vector seen", 8'(exp_q.size()), 8'h00);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule